// File: doc/BRIEF.md
# SAR Conversion Controller with Shared Read/Convert Bus

This block is the digital half of a successive-approximation converter. One active-low select line and one level input choose what a select edge means. With the level input low, a falling select begins a conversion. With it high, the same edge opens the parallel output bus for a read. The analog sample-and-hold, the capacitor DAC, the comparator and the reference sit outside the block. The comparator reaches it as a single digital input, and the DAC is driven from the trial word the block puts out.

During a conversion the block decides one bit per clock, starting with the most significant bit, and holds its busy flag low. It then hands the result to the bus in two's complement, a fixed number of cycles before busy returns high, so the rising edge of busy can latch valid data. The bus pads are tri-stated outside the block from the enable output. The enable is released while bits are being resolved. Access and release each follow a programmable cycle delay. If both control inputs are still low a set number of cycles after busy rises, a new conversion starts by itself.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, busy_n is 1, bus_oe is 0 and bus_data is all zeros.
- R2: When cs_n falls while rc is low and no conversion is running, busy_n is 0 from the next clock on.
- R3: A cs_n falling edge that arrives while busy_n is low does not start a new conversion and does not change the length of the running one.
- R4: busy_n stays low for exactly WIDTH+SETUP_CYC clock cycles per conversion.
- R5: One clock after the start, dac_word holds only the MSB set. At each later clock the trial bit is kept when cmp is 1 and cleared when cmp is 0, and the next lower bit is set. The sampled bits are thus cmp values, MSB first, and cmp=1 means the input is at or above the trial word.
- R6: The value on bus_data is the offset-binary approximation with its MSB inverted. For WIDTH=16, an input at the top code reads 7FFF, midscale reads 0000, one step below midscale reads FFFF, and the bottom code reads 8000.
- R7: With no bits being resolved, cs_n low together with rc high raises bus_oe after exactly ACC_CYC clocks, and bus_data then carries the last result.
- R8: bus_oe falls exactly REL_CYC clocks after cs_n goes high or rc goes low. It falls at once when a conversion starts, and it is never 1 while bits are being resolved. bus_data is zero whenever bus_oe is 0.
- R9: If cs_n is low and rc is high when the last bit is decided, bus_oe is 1 with the result for exactly SETUP_CYC cycles before busy_n rises, and it stays 1 afterwards.
- R10: If cs_n and rc both stay low for RETRIG_CYC clocks after busy_n rises, a new conversion starts without any new edge.
- R11: If either control input goes high inside that window, no automatic conversion starts.
- R12: A cs_n falling edge while rc is high never starts a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| rc | input | 1 | Read (high) or convert (low) select |
| cmp | input | 1 | Comparator decision, 1 when the input is at or above dac_word |
| busy_n | output | 1 | Low while a conversion runs |
| dac_word | output | WIDTH | Trial word for the capacitor DAC |
| bus_data | output | WIDTH | Two's-complement result, zero when not driven |
| bus_oe | output | 1 | Drive enable for the tri-state bus pads |

## Verification
The last bit decision and a pending read can land on the same clock. The bus must then skip its access delay, load the freshly decided word rather than the stale result, and hold it through the remaining busy-low cycles. The bench provokes this by raising rc just after starting a conversion, with cs_n held low. It counts the cycles in which bus_oe is high while busy_n is still low, and compares the word driven then with the code the modelled comparator was steering toward. A second overlap, the end of the retrigger window against a control input releasing, is judged by whether busy_n falls again after exactly the window length.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RESOLVE = 2'd1,
    ST_PRESENT = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
// Approximation engine: one bit per clock, MSB first, then a short
// presentation phase before busy returns high.
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int SETUP_CYC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp,
  output sar_state_e       state,
  output logic             busy_n,
  output logic [WIDTH-1:0] dac_word,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] final_word,
  output logic             last_bit,
  output logic             finish
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH - 1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [IW-1:0] idx;
  logic [SW-1:0] scnt;

  always_comb begin
    final_word = dac_word;
    final_word[idx] = cmp;
    if (idx != '0) final_word[idx - 1'b1] = 1'b1;
  end

  assign last_bit = (state == ST_RESOLVE) && (idx == '0);
  assign finish   = (state == ST_PRESENT) && (scnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy_n   <= 1'b1;
      dac_word <= '0;
      result   <= '0;
      idx      <= '0;
      scnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RESOLVE;
            busy_n   <= 1'b0;
            idx      <= TOP_IDX;
            dac_word <= MSB_ONLY;
          end
        end
        ST_RESOLVE: begin
          dac_word <= final_word;
          if (idx == '0) begin
            result <= final_word;
            state  <= ST_PRESENT;
            scnt   <= SW'(SETUP_CYC - 1);
          end else begin
            idx <= idx - 1'b1;
          end
        end
        ST_PRESENT: begin
          if (scnt == '0) begin
            state  <= ST_IDLE;
            busy_n <= 1'b1;
          end else begin
            scnt <= scnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_trig.sv
// Start decision: select edge with convert level, or expiry of the
// post-conversion window while both controls stay low.
module sar_trig #(
  parameter int RETRIG_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rc,
  input  logic idle,
  input  logic finish,
  output logic start
);
  localparam int WW = $clog2(RETRIG_CYC + 1);

  logic          cs_q;
  logic          win;
  logic [WW-1:0] wcnt;
  logic          both_low;
  logic          expire;

  assign both_low = ~cs_n & ~rc;
  assign expire   = win & both_low & (wcnt == WW'(RETRIG_CYC - 1));
  assign start    = idle & (((cs_q & ~cs_n) & ~rc) | expire);

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1;
      win  <= 1'b0;
      wcnt <= '0;
    end else begin
      cs_q <= cs_n;
      if (finish) begin
        win  <= 1'b1;
        wcnt <= '0;
      end else if (win) begin
        if (!both_low || start) begin
          win  <= 1'b0;
          wcnt <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_bus.sv
// Bus enable with access/release delays and two's-complement output.
module sar_bus #(
  parameter int WIDTH   = 16,
  parameter int ACC_CYC = 17,
  parameter int REL_CYC = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rc,
  input  logic             start,
  input  logic             resolving,
  input  logic             last_bit,
  input  logic [WIDTH-1:0] result,
  input  logic [WIDTH-1:0] final_word,
  output logic             bus_oe,
  output logic [WIDTH-1:0] bus_data
);
  localparam int CMAX = (ACC_CYC > REL_CYC) ? ACC_CYC : REL_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  logic          lvl;
  logic          oe_d;
  logic [CW-1:0] cnt, cnt_d;
  logic [WIDTH-1:0] src, word;

  assign lvl  = ~cs_n & rc;
  assign src  = last_bit ? final_word : result;
  assign word = {~src[WIDTH-1], src[WIDTH-2:0]};

  always_comb begin
    oe_d  = bus_oe;
    cnt_d = cnt;
    if (start || (resolving && !last_bit)) begin
      oe_d  = 1'b0;
      cnt_d = '0;
    end else if (last_bit) begin
      oe_d  = lvl;
      cnt_d = '0;
    end else if (!bus_oe) begin
      if (!lvl) cnt_d = '0;
      else if (cnt == CW'(ACC_CYC - 1)) begin
        oe_d  = 1'b1;
        cnt_d = '0;
      end else cnt_d = cnt + 1'b1;
    end else begin
      if (lvl) cnt_d = '0;
      else if (cnt == CW'(REL_CYC - 1)) begin
        oe_d  = 1'b0;
        cnt_d = '0;
      end else cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe   <= 1'b0;
      cnt      <= '0;
      bus_data <= '0;
    end else begin
      bus_oe   <= oe_d;
      cnt      <= cnt_d;
      bus_data <= oe_d ? word : '0;
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int SETUP_CYC  = 5,
  parameter int ACC_CYC    = 17,
  parameter int REL_CYC    = 17,
  parameter int RETRIG_CYC = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rc,
  input  logic             cmp,
  output logic             busy_n,
  output logic [WIDTH-1:0] dac_word,
  output logic [WIDTH-1:0] bus_data,
  output logic             bus_oe
);
  sar_state_e       state;
  logic             start, last_bit, finish;
  logic [WIDTH-1:0] result, final_word;

  sar_trig #(.RETRIG_CYC(RETRIG_CYC)) u_trig (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rc(rc),
    .idle(state == ST_IDLE), .finish(finish), .start(start)
  );

  sar_seq #(.WIDTH(WIDTH), .SETUP_CYC(SETUP_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cmp(cmp), .state(state),
    .busy_n(busy_n), .dac_word(dac_word), .result(result),
    .final_word(final_word), .last_bit(last_bit), .finish(finish)
  );

  sar_bus #(.WIDTH(WIDTH), .ACC_CYC(ACC_CYC), .REL_CYC(REL_CYC)) u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rc(rc), .start(start),
    .resolving(state == ST_RESOLVE), .last_bit(last_bit),
    .result(result), .final_word(final_word),
    .bus_oe(bus_oe), .bus_data(bus_data)
  );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int WIDTH    = 16,
  parameter int CONV_LEN = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             rc,
  input logic             busy_n,
  input logic             bus_oe,
  input logic [WIDTH-1:0] dac_word,
  input logic [WIDTH-1:0] bus_data
);
  localparam int LW = $clog2(CONV_LEN + 2) + 1;
  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk) begin
    if (rst || busy_n) lowcnt <= '0;
    else if (lowcnt != '1) lowcnt <= lowcnt + 1'b1;
  end

  p_start_convert_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> $past(!rc));

  p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |-> (lowcnt == LW'(CONV_LEN)));

  p_no_drive_resolve_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && !busy_n) |-> (lowcnt >= LW'(WIDTH)));

  p_quiet_bus_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_data == '0));

  p_access_level_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> $past(!cs_n && rc));

  p_dac_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_n && $past(busy_n)) |-> $stable(dac_word));
endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH), .CONV_LEN(WIDTH + SETUP_CYC)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rc(rc), .busy_n(busy_n),
  .bus_oe(bus_oe), .dac_word(dac_word), .bus_data(bus_data)
);

// File: tb/sar_ctrl_test.sv
module sar_ctrl_test;
  localparam int W   = 8;
  localparam int S   = 2;
  localparam int ACC = 3;
  localparam int REL = 2;
  localparam int RT  = 6;
  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic rc = 1'b0;
  logic cmp;
  logic busy_n, bus_oe;
  logic [W-1:0] dac_word, bus_data;
  logic [W-1:0] target = '0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign cmp = (target >= dac_word);

  sar_ctrl #(.WIDTH(W), .SETUP_CYC(S), .ACC_CYC(ACC), .REL_CYC(REL),
             .RETRIG_CYC(RT)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rc(rc), .cmp(cmp),
    .busy_n(busy_n), .dac_word(dac_word), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // wait until busy_n is high, return number of low negedges seen
  task automatic wait_idle(output int n);
    n = 0;
    while (!busy_n && n < 200) begin
      @(negedge clk);
      if (!busy_n) n++;
    end
  endtask

  task automatic read_back(input logic [W-1:0] t, input string req);
    int n;
    @(negedge clk); rc = 1'b1; cs_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_oe && n < 50);
    chk(n == ACC, "R7", "access delay", n, ACC);
    chk(bus_data == (t ^ MSB), req, "bus word", bus_data, t ^ MSB);
    cs_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (bus_oe && n < 50);
    chk(n == REL, "R8", "release delay", n, REL);
    chk(bus_data == '0, "R8", "idle bus word", bus_data, 0);
    rc = 1'b0;
  endtask

  task automatic convert(input logic [W-1:0] t);
    int n;
    target = t;
    @(negedge clk); cs_n = 1'b0; rc = 1'b0;
    @(negedge clk);
    chk(busy_n == 1'b0, "R2", "busy after start", busy_n, 0);
    cs_n = 1'b1;
    wait_idle(n);
    chk(n + 1 == W + S, "R4", "busy length", n + 1, W + S);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_n == 1'b1, "R1", "reset busy_n", busy_n, 1);
    chk(bus_oe == 1'b0, "R1", "reset bus_oe", bus_oe, 0);
    chk(bus_data == '0, "R1", "reset bus_data", bus_data, 0);

    // R5: trial word sequence
    target = 8'hA5;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    chk(dac_word == MSB, "R5", "first trial", dac_word, MSB);
    cs_n = 1'b1;
    @(negedge clk);
    chk(dac_word == 8'hC0, "R5", "second trial", dac_word, 8'hC0);
    wait_idle(n);
    read_back(8'hA5, "R6");

    // R6 corners then full sweep
    convert(8'hFF); read_back(8'hFF, "R6");
    convert(8'h80); read_back(8'h80, "R6");
    convert(8'h7F); read_back(8'h7F, "R6");
    convert(8'h00); read_back(8'h00, "R6");
    for (int c = 0; c < (1 << W); c++) begin
      convert(W'(c));
      read_back(W'(c), "R6");
    end

    // R3: extra edge during conversion ignored
    target = 8'h3C;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); @(negedge clk); cs_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    n = 4;
    while (!busy_n && n < 200) begin @(negedge clk); if (!busy_n) n++; end
    chk(n == W + S, "R3", "busy length with extra edge", n, W + S);
    read_back(8'h3C, "R3");

    // R12: edge with rc high never converts
    @(negedge clk); rc = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    n = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (!busy_n) n++; end
    chk(n == 0, "R12", "busy low cycles on read edge", n, 0);
    cs_n = 1'b1;
    repeat (REL + 1) @(negedge clk);
    rc = 1'b0;

    // R9: read pending when last bit decided
    target = 8'h5A;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); rc = 1'b1;
    n = 0;
    while (!busy_n) begin
      if (bus_oe) begin
        n++;
        chk(bus_data == (8'h5A ^ MSB), "R9", "early word", bus_data, 8'h5A ^ MSB);
      end
      @(negedge clk);
    end
    chk(n == S, "R9", "driven cycles before busy rise", n, S);
    chk(bus_oe == 1'b1, "R9", "bus held after busy rise", bus_oe, 1);
    cs_n = 1'b1;
    repeat (REL + 1) @(negedge clk);
    rc = 1'b0;
    chk(bus_oe == 1'b0, "R8", "released after read", bus_oe, 0);

    // R10: retrigger with both low
    target = 8'h21;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    wait_idle(n);
    n = 0;
    while (busy_n && n < 100) begin n++; @(negedge clk); end
    chk(n == RT, "R10", "retrigger gap", n, RT);
    cs_n = 1'b1;
    wait_idle(n);
    read_back(8'h21, "R10");

    // R11: window aborted by rc
    target = 8'h44;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    wait_idle(n);
    @(negedge clk); rc = 1'b1;
    n = 0;
    for (int k = 0; k < 2 * RT; k++) begin @(negedge clk); if (!busy_n) n++; end
    chk(n == 0, "R11", "busy low after abort", n, 0);
    cs_n = 1'b1;
    repeat (REL + 1) @(negedge clk);
    rc = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule